// File: doc/BRIEF.md
# Multi-Port Memory Controller Claim Router

This block sits at the front of a DRAM memory controller and decides, for each of three request sources, whether the controller takes a transaction and where it goes. Two sources are system bus ports, called north and south here. The third is a DMA port. For each bus request the block compares the address against programmable DRAM windows and a fixed register-space range. It raises a one-cycle claim or unclaimed pulse. A claimed transaction is then presented to a downstream sink over a valid/ready handshake.

North claims DRAM traffic only, through a primary window or a secondary window. South claims DRAM traffic through the primary window and also claims the controller's own register space. Register-space hits are sent to the configuration-register sink instead of the DRAM queue, and they win over any DRAM window hit. The DMA port does no decoding and forwards everything. Three window registers set the windows: the primary base, the secondary base and the shared size code. They are written through a small write port.

Top module: `mc_claim_router`

## Requirements
- R1: After reset all three window registers are zero, so no DRAM window is open. No output valid or claim/unclaimed pulse is asserted, and bus-port requests that miss register space are reported as unclaimed.
- R2: A write with `wr_en` high updates one register, chosen by `wr_sel`. Value 0 selects the primary base and value 1 selects the secondary base; `wr_data` gives address bits [31:20], and address bits [19:0] of a base are always zero. Value 2 selects the size code, taken from `wr_data[3:0]`, with the other data bits ignored. Value 3 changes nothing.
- R3: A size code k from 1 to 8 opens a window of 2^(24+k) bytes (32 MiB up to 4 GiB). Codes 0 and 9 to 15 close all windows. An address hits a window when it is at or above the base and below base plus size, with the sum computed without wrap.
- R4: North claims a request when it hits the primary or the secondary window. Every other address is unclaimed, including register-space addresses. North never drives the register sink.
- R5: South claims a DRAM access only through the primary window. The secondary window has no effect on south.
- R6: Register space is PERIPH_BASE+0x1800 through PERIPH_BASE+0x19FF inclusive. South claims it whatever the window settings are, and it takes priority over a DRAM hit. It is delivered on `s_cfg_valid` with `s_cfg_off` = address − PERIPH_BASE − 0x1800, and never on `s_q_valid`.
- R7: Every request accepted on the DMA port is claimed and forwarded to its queue with the address unchanged.
- R8: A request is accepted when its valid and ready are both high at a rising edge. After that edge, exactly one of that port's claim or unclaimed outputs is high for exactly one cycle. A claimed request's destination valid rises in the same cycle, with the request address.
- R9: A destination valid, together with its address, stays unchanged until the matching destination ready is high at an edge. `*_req_ready` is high when that port holds nothing, or when what it holds leaves in the current cycle. Unclaimed requests produce no destination output and never hold a port.
- R10: A request accepted in the same cycle as a window-register write is decoded with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Window register write strobe |
| wr_sel | input | 2 | Register select: 0 primary base, 1 secondary base, 2 size, 3 none |
| wr_data | input | 12 | Base address bits [31:20], or size code in [3:0] |
| n_req_valid | input | 1 | North request valid |
| n_req_addr | input | 32 | North request address |
| n_req_ready | output | 1 | North request ready |
| n_q_valid | output | 1 | North DRAM queue entry valid |
| n_q_addr | output | 32 | North DRAM queue address |
| n_q_ready | input | 1 | North DRAM queue ready |
| n_claim | output | 1 | North claimed pulse |
| n_unclaim | output | 1 | North unclaimed pulse |
| s_req_valid | input | 1 | South request valid |
| s_req_addr | input | 32 | South request address |
| s_req_ready | output | 1 | South request ready |
| s_q_valid | output | 1 | South DRAM queue entry valid |
| s_q_addr | output | 32 | South DRAM queue address |
| s_q_ready | input | 1 | South DRAM queue ready |
| s_cfg_valid | output | 1 | Register access valid |
| s_cfg_off | output | 9 | Register offset within register space |
| s_cfg_ready | input | 1 | Register sink ready |
| s_claim | output | 1 | South claimed pulse |
| s_unclaim | output | 1 | South unclaimed pulse |
| d_req_valid | input | 1 | DMA request valid |
| d_req_addr | input | 32 | DMA request address |
| d_req_ready | output | 1 | DMA request ready |
| d_q_valid | output | 1 | DMA queue entry valid |
| d_q_addr | output | 32 | DMA queue address |
| d_q_ready | input | 1 | DMA queue ready |
| d_claim | output | 1 | DMA accepted pulse |

## Verification
`*_req_ready` is combinational, so it is due in the same cycle as the destination readies that feed it. Claim pulses, destination valids, addresses and the register offset are all due one rising edge after acceptance. A window write affects only requests accepted at later edges. The bench drives inputs just after a falling edge and compares every output against a behavioural model 1 ns later. The model advances at each rising edge using the inputs that were present before that edge, so every result is checked in the cycle it is due and not a cycle later. Directed probes then examine the pulse and route in the cycle after each acceptance, covering window edges, register-space edges, priority and same-cycle writes.

// File: rtl/mc_claim_pkg.sv
package mc_claim_pkg;

  localparam int ADDR_W   = 32;
  localparam int ALIGN_W  = 20;
  localparam int BASE_W   = ADDR_W - ALIGN_W;
  localparam int SIZE_W   = 4;
  localparam int MIN_LOG2 = 25;
  localparam int MAX_CODE = 8;
  localparam int REG_LO   = 'h1800;
  localparam int REG_HI   = 'h19FF;
  localparam int OFF_W    = 9;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [ADDR_W:0]   wide_t;

  typedef enum logic [1:0] {
    SEL_PRI  = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_SIZE = 2'd2,
    SEL_NONE = 2'd3
  } win_sel_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_MEM  = 2'd1,
    DST_REG  = 2'd2
  } dest_e;

  typedef struct packed {
    logic [BASE_W-1:0] pri_hi;
    logic [BASE_W-1:0] sec_hi;
    logic [SIZE_W-1:0] code;
  } win_cfg_t;

  // Window span in bytes; zero means the window is closed.
  function automatic wide_t win_span(input logic [SIZE_W-1:0] code);
    wide_t s;
    s = '0;
    if (code != '0 && int'(code) <= MAX_CODE)
      s = wide_t'(1) << (MIN_LOG2 - 1 + int'(code));
    return s;
  endfunction

  // Base-inclusive, end-exclusive match computed one bit wider than the bus.
  function automatic logic win_hit(input addr_t a,
                                   input logic [BASE_W-1:0] hi,
                                   input logic [SIZE_W-1:0] code);
    wide_t lo, span, x;
    lo   = {1'b0, hi, {ALIGN_W{1'b0}}};
    span = win_span(code);
    x    = {1'b0, a};
    return (span != '0) && (x >= lo) && (x < lo + span);
  endfunction

  function automatic logic reg_hit(input addr_t a, input addr_t pb);
    wide_t x, lo, hi;
    x  = {1'b0, a};
    lo = {1'b0, pb} + wide_t'(REG_LO);
    hi = {1'b0, pb} + wide_t'(REG_HI);
    return (x >= lo) && (x <= hi);
  endfunction

  function automatic logic [OFF_W-1:0] reg_off(input addr_t a, input addr_t pb);
    return OFF_W'(a - pb - addr_t'(REG_LO));
  endfunction

endpackage

// File: rtl/mc_window_regs.sv
module mc_window_regs
  import mc_claim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BASE_W-1:0] wr_data,
  output win_cfg_t          cfg
);

  win_sel_e sel;
  logic     wr_pri, wr_sec, wr_size;

  assign sel     = win_sel_e'(wr_sel);
  assign wr_pri  = wr_en && (sel == SEL_PRI);
  assign wr_sec  = wr_en && (sel == SEL_SEC);
  assign wr_size = wr_en && (sel == SEL_SIZE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (wr_pri)  cfg.pri_hi <= wr_data;
      if (wr_sec)  cfg.sec_hi <= wr_data;
      if (wr_size) cfg.code   <= wr_data[SIZE_W-1:0];
    end
  end

  a_r2_none_sel_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_NONE) |=> $stable(cfg));

  a_r2_size_only_code: assert property (@(posedge clk) disable iff (!rst_n)
    wr_size |=> ($stable(cfg.pri_hi) && $stable(cfg.sec_hi)));

endmodule

// File: rtl/mc_port_stage.sv
module mc_port_stage
  import mc_claim_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  addr_t req_addr,
  input  logic  hit_mem,
  input  logic  hit_reg,
  input  logic  mem_ready,
  input  logic  reg_ready,
  output logic  req_ready,
  output logic  mem_valid,
  output logic  reg_valid,
  output addr_t out_addr,
  output logic  claim,
  output logic  unclaim
);

  dest_e held_dst;
  dest_e pick;
  logic  fire;
  logic  drain;
  logic  taken;

  // Register space wins over any DRAM window.
  always_comb begin
    if (hit_reg)      pick = DST_REG;
    else if (hit_mem) pick = DST_MEM;
    else              pick = DST_NONE;
  end

  assign taken     = (pick != DST_NONE);
  assign drain     = ((held_dst == DST_MEM) && mem_ready) ||
                     ((held_dst == DST_REG) && reg_ready);
  assign req_ready = (held_dst == DST_NONE) || drain;
  assign fire      = req_valid && req_ready;
  assign mem_valid = (held_dst == DST_MEM);
  assign reg_valid = (held_dst == DST_REG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_dst <= DST_NONE;
      out_addr <= '0;
      claim    <= 1'b0;
      unclaim  <= 1'b0;
    end else begin
      claim   <= fire && taken;
      unclaim <= fire && !taken;
      if (fire) begin
        held_dst <= pick;
        out_addr <= req_addr;
      end else if (drain) begin
        held_dst <= DST_NONE;
      end
    end
  end

  a_r8_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(claim && unclaim));

  a_r8_pulse_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (claim || unclaim) |-> $past(fire));

  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(out_addr)));

  a_r9_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_ready) |=> (reg_valid && $stable(out_addr)));

  a_r6_reg_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit_reg) |=> (reg_valid && !mem_valid));

endmodule

// File: rtl/mc_claim_router.sv
module mc_claim_router
  import mc_claim_pkg::*;
#(
  parameter logic [31:0] PERIPH_BASE = 32'hFFD0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [11:0] wr_data,
  input  logic        n_req_valid,
  input  logic [31:0] n_req_addr,
  output logic        n_req_ready,
  output logic        n_q_valid,
  output logic [31:0] n_q_addr,
  input  logic        n_q_ready,
  output logic        n_claim,
  output logic        n_unclaim,
  input  logic        s_req_valid,
  input  logic [31:0] s_req_addr,
  output logic        s_req_ready,
  output logic        s_q_valid,
  output logic [31:0] s_q_addr,
  input  logic        s_q_ready,
  output logic        s_cfg_valid,
  output logic [8:0]  s_cfg_off,
  input  logic        s_cfg_ready,
  output logic        s_claim,
  output logic        s_unclaim,
  input  logic        d_req_valid,
  input  logic [31:0] d_req_addr,
  output logic        d_req_ready,
  output logic        d_q_valid,
  output logic [31:0] d_q_addr,
  input  logic        d_q_ready,
  output logic        d_claim
);

  win_cfg_t cfg;
  logic     n_pri_hit, n_sec_hit, n_hit_mem;
  logic     s_hit_mem, s_hit_reg;
  logic     n_reg_v, d_reg_v, d_unclaim;
  addr_t    s_out_addr;

  mc_window_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cfg     (cfg)
  );

  // North: either DRAM window, no register space.
  assign n_pri_hit = win_hit(n_req_addr, cfg.pri_hi, cfg.code);
  assign n_sec_hit = win_hit(n_req_addr, cfg.sec_hi, cfg.code);
  assign n_hit_mem = n_pri_hit || n_sec_hit;

  // South: primary window plus register space.
  assign s_hit_mem = win_hit(s_req_addr, cfg.pri_hi, cfg.code);
  assign s_hit_reg = reg_hit(s_req_addr, PERIPH_BASE);

  mc_port_stage u_north (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (n_req_valid),
    .req_addr  (n_req_addr),
    .hit_mem   (n_hit_mem),
    .hit_reg   (1'b0),
    .mem_ready (n_q_ready),
    .reg_ready (1'b0),
    .req_ready (n_req_ready),
    .mem_valid (n_q_valid),
    .reg_valid (n_reg_v),
    .out_addr  (n_q_addr),
    .claim     (n_claim),
    .unclaim   (n_unclaim)
  );

  mc_port_stage u_south (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (s_req_valid),
    .req_addr  (s_req_addr),
    .hit_mem   (s_hit_mem),
    .hit_reg   (s_hit_reg),
    .mem_ready (s_q_ready),
    .reg_ready (s_cfg_ready),
    .req_ready (s_req_ready),
    .mem_valid (s_q_valid),
    .reg_valid (s_cfg_valid),
    .out_addr  (s_out_addr),
    .claim     (s_claim),
    .unclaim   (s_unclaim)
  );

  assign s_q_addr  = s_out_addr;
  assign s_cfg_off = reg_off(s_out_addr, PERIPH_BASE);

  // DMA: no decode, every request is taken.
  mc_port_stage u_dma (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (d_req_valid),
    .req_addr  (d_req_addr),
    .hit_mem   (1'b1),
    .hit_reg   (1'b0),
    .mem_ready (d_q_ready),
    .reg_ready (1'b0),
    .req_ready (d_req_ready),
    .mem_valid (d_q_valid),
    .reg_valid (d_reg_v),
    .out_addr  (d_q_addr),
    .claim     (d_claim),
    .unclaim   (d_unclaim)
  );

  a_r4_north_no_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !n_reg_v);

  a_r7_dma_never_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    !d_unclaim && !d_reg_v);

  a_r6_cfg_not_queued: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_q_valid && s_cfg_valid));

  a_r1_closed_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (cfg.code == '0));

endmodule

// File: tb/mc_claim_router_test.sv
module mc_claim_router_test;

  localparam logic [31:0] PB = 32'hFFD0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [11:0] wr_data = 12'd0;
  logic        n_req_valid = 1'b0, s_req_valid = 1'b0, d_req_valid = 1'b0;
  logic [31:0] n_req_addr = '0, s_req_addr = '0, d_req_addr = '0;
  logic        n_q_ready = 1'b1, s_q_ready = 1'b1, s_cfg_ready = 1'b1, d_q_ready = 1'b1;
  logic        n_req_ready, n_q_valid, n_claim, n_unclaim;
  logic        s_req_ready, s_q_valid, s_cfg_valid, s_claim, s_unclaim;
  logic        d_req_ready, d_q_valid, d_claim;
  logic [31:0] n_q_addr, s_q_addr, d_q_addr;
  logic [8:0]  s_cfg_off;

  always #4 clk = ~clk;

  mc_claim_router #(.PERIPH_BASE(PB)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .n_req_valid(n_req_valid), .n_req_addr(n_req_addr), .n_req_ready(n_req_ready),
    .n_q_valid(n_q_valid), .n_q_addr(n_q_addr), .n_q_ready(n_q_ready),
    .n_claim(n_claim), .n_unclaim(n_unclaim),
    .s_req_valid(s_req_valid), .s_req_addr(s_req_addr), .s_req_ready(s_req_ready),
    .s_q_valid(s_q_valid), .s_q_addr(s_q_addr), .s_q_ready(s_q_ready),
    .s_cfg_valid(s_cfg_valid), .s_cfg_off(s_cfg_off), .s_cfg_ready(s_cfg_ready),
    .s_claim(s_claim), .s_unclaim(s_unclaim),
    .d_req_valid(d_req_valid), .d_req_addr(d_req_addr), .d_req_ready(d_req_ready),
    .d_q_valid(d_q_valid), .d_q_addr(d_q_addr), .d_q_ready(d_q_ready),
    .d_claim(d_claim)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state: per port held flag, register-route flag, address, pulses.
  bit          mv[3], mr[3], mc[3], mu[3];
  logic [31:0] ma[3];
  logic [31:0] w_pri = '0, w_sec = '0;
  int          w_code = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [31:0] a, input logic [31:0] base);
    longint unsigned x, b, span;
    if (w_code < 1 || w_code > 8) return 1'b0;
    x = a; b = base;
    span = 64'd1 << (24 + w_code);
    return (x >= b) && ((x - b) < span);
  endfunction

  function automatic bit in_regs(input logic [31:0] a);
    longint unsigned x, b;
    x = a; b = PB;
    return (x >= b + 6144) && (x <= b + 6655);
  endfunction

  function automatic bit dst_rdy(input int p);
    if (mr[p]) return s_cfg_ready;
    case (p)
      0: return n_q_ready;
      1: return s_q_ready;
      default: return d_q_ready;
    endcase
  endfunction

  task automatic cycle();
    bit v[3], rdy, fire, hm, hr;
    logic [31:0] a[3];
    bit nv[3], nr[3], nc[3], nu[3];
    logic [31:0] na[3];
    #1;
    chk("R9 north ready", n_req_ready, !mv[0] || dst_rdy(0));
    chk("R9 south ready", s_req_ready, !mv[1] || dst_rdy(1));
    chk("R9 dma ready",   d_req_ready, !mv[2] || dst_rdy(2));
    chk("R4 north queue valid", n_q_valid, mv[0]);
    if (mv[0]) chk("R4 north queue addr", n_q_addr, ma[0]);
    chk("R5 south queue valid", s_q_valid, mv[1] && !mr[1]);
    if (mv[1] && !mr[1]) chk("R5 south queue addr", s_q_addr, ma[1]);
    chk("R6 cfg valid", s_cfg_valid, mv[1] && mr[1]);
    if (mv[1] && mr[1]) chk("R6 cfg offset", s_cfg_off, 9'((ma[1] - PB) - 32'h1800));
    chk("R7 dma queue valid", d_q_valid, mv[2]);
    if (mv[2]) chk("R7 dma queue addr", d_q_addr, ma[2]);
    chk("R8 north claim", n_claim, mc[0]);
    chk("R8 north unclaim", n_unclaim, mu[0]);
    chk("R8 south claim", s_claim, mc[1]);
    chk("R8 south unclaim", s_unclaim, mu[1]);
    chk("R8 dma claim", d_claim, mc[2]);
    v[0] = n_req_valid; v[1] = s_req_valid; v[2] = d_req_valid;
    a[0] = n_req_addr;  a[1] = s_req_addr;  a[2] = d_req_addr;
    for (int p = 0; p < 3; p++) begin
      rdy  = !mv[p] || dst_rdy(p);
      fire = v[p] && rdy;
      case (p)
        0: begin hm = in_win(a[p], w_pri) || in_win(a[p], w_sec); hr = 1'b0; end
        1: begin hm = in_win(a[p], w_pri); hr = in_regs(a[p]); end
        default: begin hm = 1'b1; hr = 1'b0; end
      endcase
      nc[p] = fire && (hm || hr);
      nu[p] = fire && !(hm || hr);
      nv[p] = mv[p]; nr[p] = mr[p]; na[p] = ma[p];
      if (fire) begin
        nv[p] = hm || hr; nr[p] = hr; na[p] = a[p];
      end else if (mv[p] && dst_rdy(p)) begin
        nv[p] = 1'b0;
      end
    end
    @(posedge clk);
    for (int p = 0; p < 3; p++) begin
      mv[p] = nv[p]; mr[p] = nr[p]; ma[p] = na[p]; mc[p] = nc[p]; mu[p] = nu[p];
    end
    if (wr_en) begin
      case (wr_sel)
        2'd0: w_pri = {wr_data, 20'h0};
        2'd1: w_sec = {wr_data, 20'h0};
        2'd2: w_code = int'(wr_data[3:0]);
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 1'b0;
    n_req_valid = 1'b0; s_req_valid = 1'b0; d_req_valid = 1'b0;
    n_q_ready = 1'b1; s_q_ready = 1'b1; s_cfg_ready = 1'b1; d_q_ready = 1'b1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [11:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    cycle();
    wr_en = 1'b0;
  endtask

  // exp: 0 unclaimed, 1 DRAM queue, 2 register sink
  task automatic probe(input int p, input logic [31:0] addr, input int exp, input string tag);
    idle();
    case (p)
      0: begin n_req_valid = 1'b1; n_req_addr = addr; end
      1: begin s_req_valid = 1'b1; s_req_addr = addr; end
      default: begin d_req_valid = 1'b1; d_req_addr = addr; end
    endcase
    cycle();
    idle();
    case (p)
      0: begin
        chk({tag, " north claim"}, n_claim, exp != 0);
        chk({tag, " north unclaim"}, n_unclaim, exp == 0);
        chk({tag, " north queue"}, n_q_valid, exp == 1);
      end
      1: begin
        chk({tag, " south claim"}, s_claim, exp != 0);
        chk({tag, " south unclaim"}, s_unclaim, exp == 0);
        chk({tag, " south queue"}, s_q_valid, exp == 1);
        chk({tag, " south cfg"}, s_cfg_valid, exp == 2);
        if (exp == 2) chk({tag, " cfg offset"}, s_cfg_off, 9'((addr - PB) - 32'h1800));
      end
      default: begin
        chk({tag, " dma claim"}, d_claim, 1'b1);
        chk({tag, " dma addr"}, d_q_addr, addr);
      end
    endcase
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R1 reset north valid", n_q_valid, 1'b0);
    chk("R1 reset south cfg", s_cfg_valid, 1'b0);
    chk("R1 reset pulses", {n_claim, n_unclaim, s_claim, s_unclaim, d_claim}, 5'b0);
    rst_n = 1'b1;
    cycle();

    // R1: windows closed after reset
    probe(0, 32'h0000_1000, 0, "R1 north closed window");
    probe(1, 32'h4000_0000, 0, "R1 south closed window");
    probe(1, PB + 32'h1800, 2, "R6 reg space with windows closed");
    probe(2, 32'h1234_5678, 1, "R7 dma forward");

    // R2/R3: primary 0x4000_0000, secondary 0x8000_0000, 32 MiB
    wr(2'd0, 12'h400);
    wr(2'd1, 12'h800);
    wr(2'd2, 12'h001);
    probe(0, 32'h3FFF_FFFF, 0, "R3 below base");
    probe(0, 32'h4000_0000, 1, "R3 at base");
    probe(0, 32'h41FF_FFFF, 1, "R3 last byte");
    probe(0, 32'h4200_0000, 0, "R3 end excluded");
    probe(0, 32'h8000_0000, 1, "R2 base low bits zero");
    probe(0, 32'h81FF_FFFF, 1, "R4 secondary hit");
    probe(1, 32'h8000_0000, 0, "R5 south ignores secondary");
    probe(1, 32'h4100_0000, 1, "R5 south primary");
    probe(0, PB + 32'h1800, 0, "R4 north ignores reg space");
    probe(1, PB + 32'h17FF, 0, "R6 below reg space");
    probe(1, PB + 32'h19FF, 2, "R6 top of reg space");
    probe(1, PB + 32'h1A00, 0, "R6 above reg space");
    probe(2, 32'hFFFF_FFFF, 1, "R7 dma any address");

    wr(2'd2, 12'h003);
    probe(0, 32'h47FF_FFFF, 1, "R3 code 3 last byte");
    probe(0, 32'h4800_0000, 0, "R3 code 3 end");
    wr(2'd3, 12'hFFF);
    probe(0, 32'h4000_0000, 1, "R2 select 3 ignored");
    probe(0, 32'hFFF0_0000, 0, "R2 select 3 ignored base");

    // R6: primary window around register space
    wr(2'd0, 12'hFFD);
    probe(1, PB + 32'h1900, 2, "R6 reg space over DRAM");
    probe(1, PB + 32'h2000, 1, "R5 window beside reg space");
    probe(0, PB + 32'h1900, 1, "R4 north DRAM at reg address");

    // R3: 4 GiB and invalid codes
    wr(2'd0, 12'h000);
    wr(2'd2, 12'h008);
    probe(0, 32'hFFFF_FFFF, 1, "R3 4GiB window top");
    probe(1, 32'h0000_0000, 1, "R3 4GiB window bottom");
    wr(2'd2, 12'h009);
    probe(0, 32'h0000_0000, 0, "R3 code 9 closed");
    wr(2'd2, 12'hFF1);
    probe(0, 32'h01FF_FFFF, 1, "R2 size from low bits");
    probe(0, 32'h0200_0000, 0, "R2 size from low bits end");

    // R10: write and request in the same cycle
    idle();
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 12'h400;
    n_req_valid = 1'b1; n_req_addr = 32'h4000_0000;
    cycle();
    idle();
    chk("R10 old window used", n_unclaim, 1'b1);
    cycle();
    probe(0, 32'h4000_0000, 1, "R10 new window later");

    // R9: back-pressure on north
    idle();
    n_q_ready = 1'b0;
    n_req_valid = 1'b1; n_req_addr = 32'h4000_0040;
    cycle();
    n_req_addr = 32'h4000_0080;
    chk("R9 north blocked", n_req_ready, 1'b0);
    chk("R9 north held", n_q_addr, 32'h4000_0040);
    for (int i = 0; i < 3; i++) cycle();
    chk("R9 north still held", n_q_addr, 32'h4000_0040);
    n_q_ready = 1'b1;
    cycle();
    n_req_valid = 1'b0;
    chk("R9 north next entry", n_q_addr, 32'h4000_0080);
    cycle();

    // R9: unclaimed traffic never blocks, even with sinks stalled
    idle();
    s_q_ready = 1'b0; s_cfg_ready = 1'b0;
    s_req_valid = 1'b1; s_req_addr = 32'h9000_0000;
    for (int i = 0; i < 4; i++) begin
      cycle();
      chk("R9 unclaimed never holds", s_req_ready, 1'b1);
    end
    idle();
    cycle();

    // Mixed random traffic against the model
    wr(2'd1, 12'h800);
    wr(2'd2, 12'h002);
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] pick[4];
      pick[0] = w_pri + ($urandom & 32'h07FF_FFFF);
      pick[1] = w_sec + ($urandom & 32'h07FF_FFFF);
      pick[2] = PB + 32'h1700 + ($urandom & 32'h3FF);
      pick[3] = $urandom;
      n_req_valid = ($urandom % 10) < 7;
      s_req_valid = ($urandom % 10) < 7;
      d_req_valid = ($urandom % 10) < 5;
      n_req_addr  = pick[$urandom % 4];
      s_req_addr  = pick[$urandom % 4];
      d_req_addr  = $urandom;
      n_q_ready   = ($urandom % 10) < 7;
      s_q_ready   = ($urandom % 10) < 7;
      s_cfg_ready = ($urandom % 10) < 6;
      d_q_ready   = ($urandom % 10) < 7;
      wr_en = ($urandom % 40) == 0;
      wr_sel = 2'($urandom);
      wr_data = (wr_sel == 2'd2) ? 12'($urandom_range(0, 10)) : 12'($urandom);
      cycle();
    end
    idle();
    repeat (4) cycle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule